// File: doc/BRIEF.md
# Serial Converter Control Interface with Power-State Sequencing

This block is the digital front end of a serial analog-to-digital converter. A host talks to it through an active-low chip select, a serial clock and a data input line. When chip select is low, the block waits for a start bit. It then collects a seven-bit control word that selects the input channel, the input polarity, single-ended or differential input, and the next power state. After that it runs an acquisition phase and a conversion phase, each a fixed number of serial clocks long. At the end of conversion it shifts the result out on the data output, most significant bit first, followed by two zero fill bits. A strobe marks the first result bit.

The block also holds the converter's power state. The power-down code in a control word only takes effect when that word's conversion completes. A start bit received while powered down wakes the block to full power. A hardware shutdown input forces the deepest power state at once and abandons any frame in progress. After reset, and after shutdown is released, the block waits a fixed number of system clocks before it accepts a start bit.

All serial inputs are oversampled by the system clock through a synchronizer, and the block acts on rising serial-clock edges. The converted value arrives on a plain parallel input. It is sampled on the rising edge that ends conversion, with no handshake, so the analog side must hold it valid by then.

Top module: `adc_serial_ctrl`

## Requirements
- R1: With chip select low, rising serial-clock edges that sample DIN low are ignored while idle. The first edge that samples DIN high is the start bit.
- R2: The seven bits after the start bit are, in arrival order: channel select (three bits, most significant first), polarity (1 = unipolar), input type (1 = single-ended), and the two-bit power code (high bit first). These fields appear on `chan_sel`, `uni_pol` and `single_end` on the edge of the seventh bit, and change at no other time.
- R3: Acquisition lasts ACQ_CLKS rising edges after the last control bit, and conversion the next CONV_CLKS edges. On the edge that ends conversion, `conv_data` is captured and its MSB appears on `dout`. Each later rising edge presents the next bit, then two 0 fill bits, then 0.
- R4: `conv_strobe` rises on the edge that ends conversion and falls on the next rising serial-clock edge.
- R5: Until the first conversion has finished, `dout` stays 0.
- R6: `dout_oe` is 1 exactly while the synchronized chip select is low. Raising chip select abandons the frame: no strobe follows, and fields not yet latched stay unchanged.
- R7: `pwr_mode` codes are 2'b11 full power, 2'b00 full power-down, and 2'b01 / 2'b10 the two low-power modes. A control word's power code is applied on the edge that ends its conversion, and not before.
- R8: A start bit accepted while `pwr_mode` is not 2'b11 sets `pwr_mode` to 2'b11.
- R9: While `shdn_n` is low, `pwr_mode` is 2'b00, no strobe occurs, `dout` is 0, and any frame in progress is abandoned.
- R10: After reset, and after `shdn_n` returns high, `pwr_mode` is 2'b11. Start bits are ignored for STARTUP_CYC system clocks.
- R11: During and just after reset: `pwr_mode` = 2'b11, `conv_strobe` = 0, the fields are 0, `dout` = 0 and `dout_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data from the host |
| shdn_n | input | 1 | Active-low hardware shutdown |
| conv_data | input | DATA_W | Converted value from the analog core |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (low = high impedance) |
| conv_strobe | output | 1 | Marks the first result bit |
| chan_sel | output | 3 | Latched channel select |
| uni_pol | output | 1 | Latched polarity (1 = unipolar) |
| single_end | output | 1 | Latched input type (1 = single-ended) |
| pwr_mode | output | 2 | Current power state code |

## Verification
Frames are sent with and without leading zero clocks. This shows that start detection keys on the first high bit and not on the first edge. The result values are chosen to tell the bit order apart: an alternating pattern, all ones, all zeros and a lone LSB. Each power code is sent in turn so that the code's delay until conversion end, and the wake on a start bit, are both seen. Chip select is cut mid-word, shutdown is asserted mid-conversion, and frames are sent inside the start-up window. These separate a completed frame from an abandoned or ignored one.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ACQ,
    PH_CONV,
    PH_OUT
  } phase_t;

  localparam logic [1:0] PM_OFF  = 2'b00;
  localparam logic [1:0] PM_FAST = 2'b01;
  localparam logic [1:0] PM_STBY = 2'b10;
  localparam logic [1:0] PM_FULL = 2'b11;

  localparam int CTRL_BITS = 7;

  typedef struct packed {
    logic [2:0] chan;
    logic       uni;
    logic       sgl;
    logic [1:0] pd;
  } ctrl_t;

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_ctl_pkg::*;
#(
  parameter int ACQ_CLKS  = 3,
  parameter int CONV_CLKS = 2,
  parameter int OUT_BITS  = 12
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_act,
  input  logic   sclk_rise,
  input  logic   din_s,
  input  logic   abort,
  input  logic   start_ok,
  output phase_t phase,
  output ctrl_t  fields,
  output ctrl_t  ctrl_nxt,
  output logic   fields_load,
  output logic   start_hit,
  output logic   conv_done
);

  localparam int M1   = (ACQ_CLKS > CONV_CLKS) ? ACQ_CLKS : CONV_CLKS;
  localparam int M2   = (OUT_BITS > CTRL_BITS) ? OUT_BITS : CTRL_BITS;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0]          cnt;
  logic [CTRL_BITS-2:0]   sh;
  logic                   live;

  assign live     = cs_act && !abort && sclk_rise;
  assign ctrl_nxt = ctrl_t'({sh, din_s});

  always_comb begin
    start_hit   = live && (phase == PH_IDLE) && din_s && start_ok;
    fields_load = live && (phase == PH_CTRL) && (cnt == CW'(CTRL_BITS - 1));
    conv_done   = live && (phase == PH_CONV) && (cnt == CW'(CONV_CLKS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      sh    <= '0;
    end else if (abort || !cs_act) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (sclk_rise) begin
      unique case (phase)
        PH_IDLE: begin
          if (start_hit) begin
            phase <= PH_CTRL;
            cnt   <= '0;
          end
        end
        PH_CTRL: begin
          sh <= {sh[CTRL_BITS-3:0], din_s};
          if (fields_load) begin
            phase <= PH_ACQ;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ACQ: begin
          if (cnt == CW'(ACQ_CLKS - 1)) begin
            phase <= PH_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_CONV: begin
          if (conv_done) begin
            phase <= PH_OUT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_OUT: begin
          if (cnt == CW'(OUT_BITS - 1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fields <= '0;
    else if (fields_load) fields <= ctrl_nxt;
  end

endmodule

// File: rtl/adc_result_shift.sv
module adc_result_shift #(
  parameter int DATA_W = 10,
  parameter int TAIL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic              msb,
  output logic              strobe
);

  localparam int OUT_W = DATA_W + TAIL_W;

  logic [OUT_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      strobe <= 1'b0;
    end else if (clear) begin
      sr     <= '0;
      strobe <= 1'b0;
    end else if (load) begin
      sr     <= {data, {TAIL_W{1'b0}}};
      strobe <= 1'b1;
    end else if (shift) begin
      sr     <= {sr[OUT_W-2:0], 1'b0};
      strobe <= 1'b0;
    end
  end

  assign msb = sr[OUT_W-1];

endmodule

// File: rtl/adc_power_ctl.sv
module adc_power_ctl
  import adc_ctl_pkg::*;
#(
  parameter int STARTUP_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_act,
  input  logic       start_hit,
  input  logic       fields_load,
  input  logic [1:0] pd_new,
  input  logic       conv_done,
  output logic [1:0] pwr_mode,
  output logic       ready
);

  localparam int WW = $clog2(STARTUP_CYC + 1);

  logic [WW-1:0] wait_cnt;
  logic [1:0]    pd_pend;
  logic          hw_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_mode <= PM_FULL;
      pd_pend  <= PM_FULL;
      hw_off   <= 1'b0;
      wait_cnt <= WW'(STARTUP_CYC);
    end else if (shdn_act) begin
      pwr_mode <= PM_OFF;
      hw_off   <= 1'b1;
      wait_cnt <= WW'(STARTUP_CYC);
    end else begin
      if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      if (fields_load)    pd_pend  <= pd_new;
      if (hw_off) begin
        hw_off   <= 1'b0;
        pwr_mode <= PM_FULL;
      end else if (conv_done) begin
        pwr_mode <= pd_pend;
      end else if (start_hit) begin
        pwr_mode <= PM_FULL;
      end
    end
  end

  assign ready = (wait_cnt == '0) && !hw_off;

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int TAIL_W      = 2,
  parameter int ACQ_CLKS    = 3,
  parameter int CONV_CLKS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STARTUP_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              shdn_n,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              conv_strobe,
  output logic [2:0]        chan_sel,
  output logic              uni_pol,
  output logic              single_end,
  output logic [1:0]        pwr_mode
);

  localparam int OUT_BITS = DATA_W + TAIL_W;

  logic [3:0] pins_s;
  logic       shdn_s, cs_s, sclk_s, din_s;
  logic       sclk_prev, sclk_rise;
  logic       cs_act, shdn_act;
  phase_t     cur_phase;
  ctrl_t      fields, ctrl_nxt;
  logic       fields_load, start_hit, conv_done, ready;

  adc_in_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({shdn_n, cs_n, sclk, din}),
    .q     (pins_s)
  );

  assign {shdn_s, cs_s, sclk_s, din_s} = pins_s;
  assign cs_act   = !cs_s;
  assign shdn_act = !shdn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_prev;

  adc_frame_seq #(
    .ACQ_CLKS  (ACQ_CLKS),
    .CONV_CLKS (CONV_CLKS),
    .OUT_BITS  (OUT_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .sclk_rise   (sclk_rise),
    .din_s       (din_s),
    .abort       (shdn_act),
    .start_ok    (ready),
    .phase       (cur_phase),
    .fields      (fields),
    .ctrl_nxt    (ctrl_nxt),
    .fields_load (fields_load),
    .start_hit   (start_hit),
    .conv_done   (conv_done)
  );

  adc_result_shift #(
    .DATA_W (DATA_W),
    .TAIL_W (TAIL_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (shdn_act || !cs_act),
    .load   (conv_done),
    .shift  (sclk_rise && (cur_phase == PH_OUT)),
    .data   (conv_data),
    .msb    (dout),
    .strobe (conv_strobe)
  );

  adc_power_ctl #(
    .STARTUP_CYC (STARTUP_CYC)
  ) u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .shdn_act    (shdn_act),
    .start_hit   (start_hit),
    .fields_load (fields_load),
    .pd_new      (ctrl_nxt.pd),
    .conv_done   (conv_done),
    .pwr_mode    (pwr_mode),
    .ready       (ready)
  );

  assign dout_oe    = cs_act;
  assign chan_sel   = fields.chan;
  assign uni_pol    = fields.uni;
  assign single_end = fields.sgl;

endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk
  import adc_ctl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       shdn_n,
  input logic       dout,
  input logic       dout_oe,
  input logic       conv_strobe,
  input logic [2:0] chan_sel,
  input logic [1:0] pwr_mode,
  input logic       fields_load,
  input phase_t     cur_phase
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen <= 1'b0;
    else if (conv_strobe) seen <= 1'b1;
  end

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !dout_oe);

  // R9
  shdn_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n && !$past(shdn_n) && !$past(shdn_n, 2) && !$past(shdn_n, 3))
      |-> (pwr_mode == PM_OFF && !conv_strobe && !dout));

  // R5
  zero_before_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !conv_strobe) |-> !dout);

  // R2
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fields_load |=> $stable(chan_sel));

  // R4
  strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_strobe) |-> ($past(cur_phase) == PH_CONV));

endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .shdn_n      (shdn_n),
  .dout        (dout),
  .dout_oe     (dout_oe),
  .conv_strobe (conv_strobe),
  .chan_sel    (chan_sel),
  .pwr_mode    (pwr_mode),
  .fields_load (fields_load),
  .cur_phase   (cur_phase)
);

// File: tb/sim_adc_serial_ctrl.sv
`timescale 1ns/1ps
module sim_adc_serial_ctrl;

  localparam int HALF   = 6;
  localparam int ACQ    = 3;
  localparam int CONV   = 2;
  localparam int OUTB   = 12;
  localparam int RISES  = 8 + ACQ + CONV + OUTB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b0, shdn_n = 1'b1;
  logic [9:0] conv_data = '0;
  logic       dout, dout_oe, conv_strobe, uni_pol, single_end;
  logic [2:0] chan_sel;
  logic [1:0] pwr_mode;

  int total = 0;
  int bad = 0;
  int n_strobe = 0;
  logic [11:0] exp_q[$];
  logic [11:0] got;
  logic [11:0] want;
  logic [1:0]  start_pwr, mid_pwr;
  logic        mid_oe;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  adc_serial_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .shdn_n(shdn_n), .conv_data(conv_data), .dout(dout), .dout_oe(dout_oe),
    .conv_strobe(conv_strobe), .chan_sel(chan_sel), .uni_pol(uni_pol),
    .single_end(single_end), .pwr_mode(pwr_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic pulse(input logic b);
    sclk = 1'b0; din = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_frame(input logic [6:0] ctl, input logic [9:0] data,
                           input int lead, input int cut_at, input int shdn_at,
                           input bit expect_ok);
    logic [7:0] bits;
    bits = {1'b1, ctl};
    conv_data = data;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    if (expect_ok) exp_q.push_back({data, 2'b00});
    for (int i = 0; i < lead; i++) pulse(1'b0);
    for (int k = 1; k <= RISES; k++) begin
      if (cut_at != 0 && k > cut_at) break;
      sclk = 1'b0;
      din  = (k <= 8) ? bits[8-k] : 1'b0;
      if (k == shdn_at) shdn_n = 1'b0;
      repeat (HALF) @(negedge clk);
      if (k == 2) start_pwr = pwr_mode;
      if (k == 9) begin mid_pwr = pwr_mode; mid_oe = dout_oe; end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (2*HALF) @(negedge clk);
    cs_n = 1'b1; din = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // monitor: collects each result word after a strobe and scores it
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && conv_strobe) begin
        n_strobe++;
        for (int i = 0; i < OUTB; i++) begin
          if (i > 0) while (sclk !== 1'b1) @(negedge clk);
          while (sclk !== 1'b0) @(negedge clk);
          @(negedge clk);
          got[OUTB-1-i] = dout;
          if (i == 0) check(conv_strobe == 1'b1, "R4 strobe high on first bit", conv_strobe, 1);
          if (i == 1) check(conv_strobe == 1'b0, "R4 strobe low on second bit", conv_strobe, 0);
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected result word", got, 0);
        end else begin
          want = exp_q.pop_front();
          check(got == want, "R3 result word order", got, want);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_up();
    end
  end

  initial begin
    int s0;
    repeat (5) @(negedge clk);
    check(pwr_mode == 2'b11, "R11 reset pwr_mode", pwr_mode, 3);
    check(conv_strobe == 1'b0, "R11 reset strobe", conv_strobe, 0);
    check(chan_sel == 3'd0, "R11 reset chan_sel", chan_sel, 0);
    check(dout == 1'b0, "R11 reset dout", dout, 0);
    check(dout_oe == 1'b0, "R11 reset dout_oe", dout_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: frame inside the start-up window is ignored
    run_frame(7'b1011011, 10'h2A5, 0, 8, 0, 1'b0);
    check(chan_sel == 3'd0, "R10 start-up ignores start bit", chan_sel, 0);
    check(n_strobe == 0, "R10 no strobe during start-up", n_strobe, 0);
    repeat (600) @(negedge clk);

    // R5, R6, R1: zero clocks before any conversion
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      pulse(1'b0);
      check(dout == 1'b0, "R5 dout zero before first conversion", dout, 0);
      check(dout_oe == 1'b1, "R6 dout_oe with cs low", dout_oe, 1);
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    check(chan_sel == 3'd0 && n_strobe == 0, "R1 zero bits start nothing", chan_sel, 0);

    // frame A: chan 5, unipolar, differential, full power
    run_frame(7'b1011011, 10'h2A5, 0, 0, 0, 1'b1);
    check(chan_sel == 3'd5, "R2 chan_sel", chan_sel, 5);
    check(uni_pol == 1'b1, "R2 uni_pol", uni_pol, 1);
    check(single_end == 1'b0, "R2 single_end", single_end, 0);
    check(pwr_mode == 2'b11, "R7 pwr full", pwr_mode, 3);

    // frame B: leading zeros, code 01 applied after conversion
    run_frame(7'b0100101, 10'h3FF, 3, 0, 0, 1'b1);
    check(mid_pwr == 2'b11, "R7 code not applied before conversion end", mid_pwr, 3);
    check(mid_oe == 1'b1, "R6 dout_oe mid frame", mid_oe, 1);
    check(pwr_mode == 2'b01, "R7 code 01 applied", pwr_mode, 1);
    check(chan_sel == 3'd2 && single_end == 1'b1 && uni_pol == 1'b0, "R1 R2 fields after lead zeros", chan_sel, 2);

    // frame C: wake from 01, program 00
    run_frame(7'b1111100, 10'h000, 0, 0, 0, 1'b1);
    check(start_pwr == 2'b11, "R8 start bit wakes from 01", start_pwr, 3);
    check(pwr_mode == 2'b00, "R7 code 00 applied", pwr_mode, 0);

    // frame D: wake from 00, program 10
    run_frame(7'b0010010, 10'h155, 0, 0, 0, 1'b1);
    check(start_pwr == 2'b11, "R8 start bit wakes from 00", start_pwr, 3);
    check(pwr_mode == 2'b10, "R7 code 10 applied", pwr_mode, 2);

    // frame E: shutdown during conversion
    s0 = n_strobe;
    run_frame(7'b0111111, 10'h0F0, 0, 0, 12, 1'b0);
    check(pwr_mode == 2'b00, "R9 shutdown forces 00", pwr_mode, 0);
    check(n_strobe == s0, "R9 conversion aborted", n_strobe, s0);
    check(dout == 1'b0, "R9 dout zero in shutdown", dout, 0);
    check(chan_sel == 3'd3, "R2 fields latched before shutdown", chan_sel, 3);
    shdn_n = 1'b1;
    repeat (8) @(negedge clk);
    check(pwr_mode == 2'b11, "R10 full power after shutdown release", pwr_mode, 3);
    run_frame(7'b1100011, 10'h111, 0, 8, 0, 1'b0);
    check(chan_sel == 3'd3, "R10 start ignored after release", chan_sel, 3);
    check(n_strobe == s0, "R10 no strobe after release", n_strobe, s0);
    repeat (600) @(negedge clk);

    // frame G: normal after wait
    run_frame(7'b1001011, 10'h001, 0, 0, 0, 1'b1);
    check(chan_sel == 3'd4, "R2 chan_sel after recovery", chan_sel, 4);

    // frame H: chip select cut mid control word
    s0 = n_strobe;
    run_frame(7'b0000000, 10'h3C3, 0, 5, 0, 1'b0);
    check(dout_oe == 1'b0, "R6 dout_oe low with cs high", dout_oe, 0);
    check(chan_sel == 3'd4, "R6 cut frame leaves fields", chan_sel, 4);
    check(n_strobe == s0, "R6 cut frame gives no strobe", n_strobe, s0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected words produced", exp_q.size(), 0);
    done = 1'b1;
    finish_up();
  end

endmodule